// File: doc/BRIEF.md
# FP64 predicate compare evaluator

This block compares two IEEE-754 binary64 operands, A and B, under a 5-bit predicate code. It returns one boolean result, an invalid-operation flag and a denormal flag. Internally it sorts each operand pair into one of four mutually exclusive relations: greater, less, equal or unordered. Each predicate code maps to a 4-bit truth mask over those relations, and the result is the mask bit of the relation that holds. The block does not trap exceptions. It only reports the flags.

A legacy-mode input keeps only the three low predicate bits, so eight predicates are reachable. If either of the two high bits is set in that mode, the code is flagged as reserved. The outputs are registered, which gives one cycle of latency. This lets a vector datapath use one instance per lane and take the lane results together on the next clock.

Top module: `fp64_pred_cmp`

## Requirements
- R1: All outputs are registered with one cycle of latency. While rst_ni is low, result_o, invalid_o, denorm_o and reserved_o are 0.
- R2: Operands that are not NaN are ordered by value. Infinities are the extremes. When both signs are negative, the magnitude order is reversed.
- R3: +0 and -0 compare equal.
- R4: An operand with an all-ones exponent and a nonzero fraction is a NaN. If either operand is a NaN, the relation is unordered, and only the unordered mask bit decides the result.
- R5: Truth masks are written as {greater, less, equal, unordered}. For codes 0 to 15 they are:
  - 3:0001, 11:0000, 15:1111
  - 0:0010, 8:0011, 12:1100, 4:1101
  - 1:0100, 9:0101, 2:0110, 10:0111
  - 14:1000, 6:1001, 13:1010, 5:1011, 7:1110
- R6: Codes 16 to 31 use the mask of the code minus 16.
- R7: A signaling NaN (fraction bit 51 equal to 0) in either operand sets invalid_o for every predicate.
- R8: A quiet NaN in either operand sets invalid_o only for signaling predicates. Among codes 0 to 15, the signaling codes are 1, 2, 5, 6, 9, 10, 13 and 14. For codes 16 to 31 the choice is inverted.
- R9: denorm_o is 1 when either operand has a zero exponent and a nonzero fraction.
- R10: When legacy_i is 1, only pred_i[2:0] selects the predicate, and reserved_o is 1 if pred_i[4:3] is nonzero. When legacy_i is 0, reserved_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | Operand A, binary64 |
| b_i | input | 64 | Operand B, binary64 |
| pred_i | input | 5 | Predicate code |
| legacy_i | input | 1 | Restricts the predicate to its three low bits |
| result_o | output | 1 | Predicate outcome |
| invalid_o | output | 1 | Invalid-operation flag |
| denorm_o | output | 1 | Subnormal operand flag |
| reserved_o | output | 1 | Reserved code seen in legacy mode |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and a registered output. With these values the operand format is exactly binary64. The reference model can therefore order operands with native real comparison instead of bit arithmetic, which keeps it independent of the sign-magnitude logic. The registered output makes the one-cycle latency and the reset state observable. The bench sweeps every pair drawn from a pool of zeros, normals, subnormals, infinities and both NaN kinds. Each pair runs through all 32 codes in both modes, followed by random pairs.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int PRED_W = 5;
  localparam int LEG_W  = 3;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
    logic zero;
    logic sub;
  } fp_class_t;

  // bit order gt, lt, eq, un matches the truth-mask layout
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic un;
  } rel_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output fp_class_t    cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz;

  assign exp_f   = op_i[W-2:FRAC_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls_o.nan  = exp_max & frac_nz;
    cls_o.qnan = exp_max & frac_nz & frac_f[FRAC_W-1];
    cls_o.snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.zero = exp_min & ~frac_nz;
    cls_o.sub  = exp_min & frac_nz;
  end
endmodule

// File: rtl/fp_relation.sv
module fp_relation
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fp_class_t    cls_a_i,
  input  fp_class_t    cls_b_i,
  output rel_t         rel_o
);
  logic [W-2:0] mag_a, mag_b;
  logic sgn_a, sgn_b, mag_gt;

  assign mag_a  = a_i[W-2:0];
  assign mag_b  = b_i[W-2:0];
  assign sgn_a  = a_i[W-1];
  assign sgn_b  = b_i[W-1];
  assign mag_gt = mag_a > mag_b;

  always_comb begin
    rel_o = '0;
    if (cls_a_i.nan || cls_b_i.nan) begin
      rel_o.un = 1'b1;
    end else if ((cls_a_i.zero && cls_b_i.zero) || (a_i == b_i)) begin
      rel_o.eq = 1'b1;
    end else if (sgn_a != sgn_b) begin
      rel_o.gt = sgn_b;
      rel_o.lt = sgn_a;
    end else begin
      // both negative: larger magnitude is the smaller value
      rel_o.gt = mag_gt ^ sgn_a;
      rel_o.lt = ~(mag_gt ^ sgn_a);
    end
  end
endmodule

// File: rtl/pred_decode.sv
module pred_decode
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] pred_i,
  input  logic              legacy_i,
  output logic [3:0]        mask_o,
  output logic              sig_q_o,
  output logic              reserved_o
);
  logic [PRED_W-1:0] code;

  assign code       = legacy_i ? {{(PRED_W-LEG_W){1'b0}}, pred_i[LEG_W-1:0]} : pred_i;
  assign reserved_o = legacy_i & (|pred_i[PRED_W-1:LEG_W]);
  // signaling when low two bits differ; upper half inverts the choice
  assign sig_q_o    = (code[0] ^ code[1]) ^ code[4];

  always_comb begin
    unique case (code[3:0])
      4'h0: mask_o = 4'b0010;
      4'h1: mask_o = 4'b0100;
      4'h2: mask_o = 4'b0110;
      4'h3: mask_o = 4'b0001;
      4'h4: mask_o = 4'b1101;
      4'h5: mask_o = 4'b1011;
      4'h6: mask_o = 4'b1001;
      4'h7: mask_o = 4'b1110;
      4'h8: mask_o = 4'b0011;
      4'h9: mask_o = 4'b0101;
      4'hA: mask_o = 4'b0111;
      4'hB: mask_o = 4'b0000;
      4'hC: mask_o = 4'b1100;
      4'hD: mask_o = 4'b1010;
      4'hE: mask_o = 4'b1000;
      default: mask_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/fp64_pred_cmp.sv
module fp64_pred_cmp
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              legacy_i,
  output logic              result_o,
  output logic              invalid_o,
  output logic              denorm_o,
  output logic              reserved_o
);
  fp_class_t cls_a, cls_b;
  rel_t      rel;
  logic [3:0] mask;
  logic sig_q, rsv;
  logic res_d, inv_d, den_d;

  fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.op_i(a_i), .cls_o(cls_a));
  fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.op_i(b_i), .cls_o(cls_b));

  fp_relation #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rel (
    .a_i(a_i), .b_i(b_i), .cls_a_i(cls_a), .cls_b_i(cls_b), .rel_o(rel)
  );

  pred_decode u_dec (
    .pred_i(pred_i), .legacy_i(legacy_i),
    .mask_o(mask), .sig_q_o(sig_q), .reserved_o(rsv)
  );

  assign res_d = |(mask & rel);
  assign inv_d = cls_a.snan | cls_b.snan | ((cls_a.qnan | cls_b.qnan) & sig_q);
  assign den_d = cls_a.sub | cls_b.sub;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o   <= 1'b0;
          invalid_o  <= 1'b0;
          denorm_o   <= 1'b0;
          reserved_o <= 1'b0;
        end else begin
          result_o   <= res_d;
          invalid_o  <= inv_d;
          denorm_o   <= den_d;
          reserved_o <= rsv;
        end
      end
    end else begin : g_comb
      assign result_o   = res_d;
      assign invalid_o  = inv_d;
      assign denorm_o   = den_d;
      assign reserved_o = rsv;
    end
  endgenerate
endmodule

// File: rtl/fp64_pred_cmp_chk.sv
module fp64_pred_cmp_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   pred_i,
  input logic         legacy_i,
  input logic         result_o,
  input logic         invalid_o,
  input logic         denorm_o,
  input logic         reserved_o,
  input logic [3:0]   rel_i
);
  logic nan_a, nan_b, snan_a, snan_b, sub_a, sub_b;
  assign nan_a  = (&a_i[W-2:FRAC_W]) && (|a_i[FRAC_W-1:0]);
  assign nan_b  = (&b_i[W-2:FRAC_W]) && (|b_i[FRAC_W-1:0]);
  assign snan_a = nan_a && !a_i[FRAC_W-1];
  assign snan_b = nan_b && !b_i[FRAC_W-1];
  assign sub_a  = (a_i[W-2:FRAC_W] == '0) && (|a_i[FRAC_W-1:0]);
  assign sub_b  = (b_i[W-2:FRAC_W] == '0) && (|b_i[FRAC_W-1:0]);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!result_o && !invalid_o && !denorm_o && !reserved_o);
    end
  end

  assert_rel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(rel_i));

  assert_unord_pred_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nan_a || nan_b) && pred_i == 5'd3) |=> result_o);

  assert_false_pred_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_i && pred_i[3:0] == 4'hB) |=> !result_o);

  assert_snan_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snan_a || snan_b) |=> invalid_o);

  assert_sub_denorm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_a || sub_b) |=> denorm_o);

  assert_legacy_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_i && (|pred_i[4:3])) |=> reserved_o);

  assert_ext_no_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i |=> !reserved_o);
endmodule

bind fp64_pred_cmp fp64_pred_cmp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .pred_i(pred_i),
  .legacy_i(legacy_i), .result_o(result_o), .invalid_o(invalid_o),
  .denorm_o(denorm_o), .reserved_o(reserved_o), .rel_i(rel)
);

// File: tb/tb_fp64_pred_cmp.sv
`timescale 1ns/1ps
module tb_fp64_pred_cmp;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [63:0] a_i, b_i;
  logic [4:0]  pred_i;
  logic        legacy_i;
  logic        result_o, invalid_o, denorm_o, reserved_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  fp64_pred_cmp dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .pred_i(pred_i),
    .legacy_i(legacy_i), .result_o(result_o), .invalid_o(invalid_o),
    .denorm_o(denorm_o), .reserved_o(reserved_o)
  );

  logic [63:0] pool [15];

  function automatic bit is_nan(input logic [63:0] x);
    return (&x[62:52]) && (|x[51:0]);
  endfunction

  function automatic bit is_sub(input logic [63:0] x);
    return (x[62:52] == 11'd0) && (|x[51:0]);
  endfunction

  // R5 masks as {gt, lt, eq, un}
  function automatic logic [3:0] ref_mask(input int c);
    case (c)
      0: return 4'b0010;   1: return 4'b0100;   2: return 4'b0110;   3: return 4'b0001;
      4: return 4'b1101;   5: return 4'b1011;   6: return 4'b1001;   7: return 4'b1110;
      8: return 4'b0011;   9: return 4'b0101;  10: return 4'b0111;  11: return 4'b0000;
      12: return 4'b1100; 13: return 4'b1010;  14: return 4'b1000;  default: return 4'b1111;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h pred=%0d leg=%0b actual=%0b expected=%0b",
               tag, a_i, b_i, pred_i, legacy_i, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] p, input logic leg);
    int code, low;
    bit un, gt, lt, eq, sig, snan, qnan;
    logic [3:0] m;
    logic exp_res;
    real ra, rb;
    string rtag;
    a_i = a; b_i = b; pred_i = p; legacy_i = leg;
    un = is_nan(a) || is_nan(b);
    gt = 0; lt = 0; eq = 0;
    if (!un) begin
      ra = $bitstoreal(a); rb = $bitstoreal(b);
      gt = ra > rb; lt = ra < rb; eq = ra == rb;
    end
    code = leg ? int'(p[2:0]) : int'(p);
    low  = code % 16;
    m    = ref_mask(low);
    exp_res = (gt & m[3]) | (lt & m[2]) | (eq & m[1]) | (un & m[0]);
    sig  = (low == 1 || low == 2 || low == 5 || low == 6 ||
            low == 9 || low == 10 || low == 13 || low == 14);
    if (code >= 16) sig = !sig;
    snan = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    qnan = (is_nan(a) && a[51]) || (is_nan(b) && b[51]);
    if (un) rtag = "R4";
    else if (a[62:0] == 63'd0 && b[62:0] == 63'd0) rtag = "R3";
    else rtag = "R2";
    rtag = {rtag, (code >= 16) ? " R6" : " R5", leg ? " R10" : ""};
    @(posedge clk_i);
    @(negedge clk_i);
    check({"result ", rtag}, result_o, exp_res);
    check(snan ? "invalid R7" : "invalid R8", invalid_o, snan || (qnan && sig));
    check("denorm R9", denorm_o, is_sub(a) || is_sub(b));
    check("reserved R10", reserved_o, leg && (p[4:3] != 2'b00));
  endtask

  initial begin
    pool[0]  = 64'h0000000000000000; pool[1]  = 64'h8000000000000000;
    pool[2]  = 64'h3FF0000000000000; pool[3]  = 64'hBFF0000000000000;
    pool[4]  = 64'h4000000000000000; pool[5]  = 64'hC000000000000000;
    pool[6]  = 64'h3FF8000000000000; pool[7]  = 64'h0000000000000001;
    pool[8]  = 64'h8000000000000001; pool[9]  = 64'h7FF0000000000000;
    pool[10] = 64'hFFF0000000000000; pool[11] = 64'h7FF8000000000000;
    pool[12] = 64'h7FF0000000000001; pool[13] = 64'hFFF8000000000001;
    pool[14] = 64'h7FEFFFFFFFFFFFFF;
    rst_ni = 1'b0; a_i = '0; b_i = '0; pred_i = '0; legacy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("reset result R1", result_o, 1'b0);
    check("reset invalid R1", invalid_o, 1'b0);
    check("reset denorm R1", denorm_o, 1'b0);
    check("reset reserved R1", reserved_o, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++)
        for (int p = 0; p < 32; p++)
          for (int l = 0; l < 2; l++)
            apply(pool[i], pool[j], 5'(p), 1'(l));
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] ra_v, rb_v;
      ra_v = {$urandom, $urandom};
      rb_v = ($urandom % 4 == 0) ? ra_v ^ 64'(1 << ($urandom % 3)) : {$urandom, $urandom};
      if ($urandom % 5 == 0) ra_v = pool[$urandom % 15];
      apply(ra_v, rb_v, 5'($urandom), 1'($urandom % 2));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(64'd190000 * 64'd20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule